// File: doc/BRIEF.md
# Byte-Wide Cascaded Interrupt Aggregator

This block collects up to 24 peripheral interrupt requests and merges them into one interrupt line for a host processor. The host treats that line as rising-edge triggered. Sources are grouped into banks of eight. Each bank has a status byte that the host reads and an enable byte that the host writes. The same parameter vector marks every source as either edge-captured or level-sensitive. With the default settings, source 11 is the level-sensitive source and all other sources are edge-captured.

Every request first passes through a two-flop synchronizer. A rising edge on an edge-captured source is latched only while that source's enable bit is set. Reading a bank's status byte acknowledges that bank: the read clears the latched edges of that bank and leaves the other banks alone. There is no separate acknowledge write. A level-sensitive source is never latched. Its status bit shows the synchronized input at all times. The output line is the registered OR of every enabled pending bit. It falls once nothing enabled is pending, so the next event produces a new rising edge.

The host bus has a 2-bit address. Address k (0 to 2) reads the status byte of bank k and writes the enable byte of bank k. Address 3 is auxiliary. A write to address 3 stores a view selector. A read of address 3 returns the enable byte of the bank that the selector names, which lets the host do a read-modify-write of an enable byte.

Top module: `irq_cascade_agg`

## Requirements
- R1: Source i is reported in bank i/8 at bit i%8. A read of address k (0, 1 or 2) returns the status byte of bank k, and read data is valid in the same cycle as rd_en.
- R2: A write to address k (0 to 2) loads the enable byte of bank k. A write to address 3 loads the view selector. A read of address 3 returns the enable byte of bank 0, 1 or 2 when the selector holds 0, 1 or 2, and returns 0x00 for any other selector value.
- R3: The level-sensitive source (index 11, bank 1 bit 3) has a status bit that follows its synchronized input whether or not the source is enabled. Status reads do not clear this bit.
- R4: After reset, all enable bytes, all status bits, the view selector and irq_o are 0.
- R5: A rising edge on an edge-captured source whose enable bit is 0 is not kept. An input that is already high when its enable bit is set produces no pending bit and no output.
- R6: A status read returns the byte as it stood before the read. At that clock edge the read clears the latched edge bits of that bank only.
- R7: irq_o is 1 in the cycle after any enabled pending bit is 1, and 0 in the cycle after no enabled pending bit is 1.
- R8: A new enabled edge that is latched in the same cycle as a clearing read of its bank remains set. The read returns the byte without that bit, and the next read returns it.
- R9: An edge-captured, enabled input driven high between clock edges raises irq_o on the fourth rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 24 | Asynchronous peripheral request inputs |
| rd_en | input | 1 | Read strobe; a status read clears that bank's latched edges |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address: 0 to 2 for banks, 3 for the auxiliary view |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Combined interrupt output |

## Verification
A latched edge bit that is lost or stuck shows up at the port through two paths. irq_o fails to rise or fails to fall one cycle after the pending set changes. The next status read of that bank returns the wrong byte. A wrong enable byte is visible at once through the auxiliary view, and it is also visible four cycles after any edge on that bank, when irq_o should have changed. The same-cycle race between an incoming edge and a clearing read shows up across two consecutive reads: the first must omit the bit and the second must report it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ADDR_W = 2;
   localparam int MAX_BANKS = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_BANK0 = 2'd0,
      REG_BANK1 = 2'd1,
      REG_BANK2 = 2'd2,
      REG_AUX   = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (STAGES < 2) $fatal(1, "irq_sync: STAGES must be at least 2");
      if (W < 1)      $fatal(1, "irq_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_capture_bank.sv
module irq_capture_bank #(
   parameter int           W           = 8,
   parameter int           SYNC_STAGES = 2,
   parameter logic [W-1:0] LEVEL_MASK  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req_i,
   input  logic [W-1:0] en_i,
   input  logic         clr_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] pend_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] lat_o
);
   logic [W-1:0] sync_w;

   irq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (req_i),
      .q_o   (sync_w)
   );

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         if (LEVEL_MASK[b]) begin : g_level
            // live level: status tracks the synchronized request
            assign status_o[b] = sync_w[b];
            assign rise_o[b]   = 1'b0;
            assign lat_o[b]    = 1'b0;
         end else begin : g_edge
            logic prev_q;
            logic lat_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) prev_q <= 1'b0;
               else        prev_q <= sync_w[b];
            end
            assign rise_o[b] = sync_w[b] & ~prev_q;
            // a fresh enabled edge takes priority over a clearing read
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                  lat_q <= 1'b0;
               else if (rise_o[b] & en_i[b]) lat_q <= 1'b1;
               else if (clr_i)               lat_q <= 1'b0;
            end
            assign status_o[b] = lat_q;
            assign lat_o[b]    = lat_q;
         end
      end
   endgenerate

   assign pend_o = status_o & en_i;
endmodule

// File: rtl/irq_regif.sv
module irq_regif
   import irq_agg_pkg::*;
#(
   parameter int N_BANKS = 3,
   parameter int DATA_W  = 8,
   localparam int VEC_W  = N_BANKS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [VEC_W-1:0]  status_i,
   output logic [VEC_W-1:0]  en_o,
   output logic [N_BANKS-1:0] clr_o,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] view_q;
   logic [DATA_W-1:0] view_byte;

   generate
      for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
         logic [DATA_W-1:0] en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             en_q <= '0;
            else if (wr_en && addr == ADDR_W'(k))   en_q <= wr_data;
         end
         assign en_o[k*DATA_W +: DATA_W] = en_q;
         assign clr_o[k] = rd_en && (addr == ADDR_W'(k));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          view_q <= '0;
      else if (wr_en && addr == REG_AUX)   view_q <= wr_data;
   end

   always_comb begin
      view_byte = '0;
      for (int k = 0; k < N_BANKS; k++) begin
         if (view_q == DATA_W'(k)) view_byte = en_o[k*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == REG_AUX) begin
         rd_data = view_byte;
      end else begin
         for (int k = 0; k < N_BANKS; k++) begin
            if (addr == ADDR_W'(k)) rd_data = status_i[k*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
   import irq_agg_pkg::*;
#(
   parameter int   N_BANKS     = 3,
   parameter int   DATA_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic [N_BANKS*DATA_W-1:0] LEVEL_MASK = 24'h00_0800,
   localparam int  N_SRC       = N_BANKS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_o
);
   initial begin
      if (N_BANKS < 1 || N_BANKS > MAX_BANKS)
         $fatal(1, "irq_cascade_agg: N_BANKS out of range");
      if (DATA_W != 8)
         $fatal(1, "irq_cascade_agg: bus is byte wide");
   end

   logic [N_SRC-1:0]   en_vec;
   logic [N_SRC-1:0]   status_vec;
   logic [N_SRC-1:0]   pend_vec;
   logic [N_SRC-1:0]   rise_vec;
   logic [N_SRC-1:0]   edge_lat_vec;
   logic [N_BANKS-1:0] clr_vec;
   logic               irq_q;

   irq_regif #(.N_BANKS(N_BANKS), .DATA_W(DATA_W)) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .status_i (status_vec),
      .en_o     (en_vec),
      .clr_o    (clr_vec),
      .rd_data  (rd_data)
   );

   generate
      for (genvar k = 0; k < N_BANKS; k++) begin : g_cap
         irq_capture_bank #(
            .W           (DATA_W),
            .SYNC_STAGES (SYNC_STAGES),
            .LEVEL_MASK  (LEVEL_MASK[k*DATA_W +: DATA_W])
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (src_i[k*DATA_W +: DATA_W]),
            .en_i     (en_vec[k*DATA_W +: DATA_W]),
            .clr_i    (clr_vec[k]),
            .status_o (status_vec[k*DATA_W +: DATA_W]),
            .pend_o   (pend_vec[k*DATA_W +: DATA_W]),
            .rise_o   (rise_vec[k*DATA_W +: DATA_W]),
            .lat_o    (edge_lat_vec[k*DATA_W +: DATA_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend_vec;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
   parameter int N_BANKS = 3,
   parameter int DATA_W  = 8,
   localparam int VEC_W  = N_BANKS * DATA_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic [1:0]       addr,
   input logic             irq_o,
   input logic [VEC_W-1:0] en_vec,
   input logic [VEC_W-1:0] rise_vec,
   input logic [VEC_W-1:0] edge_lat_vec,
   input logic [VEC_W-1:0] pend_vec
);
   p_reset_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_vec == '0 && !irq_o && edge_lat_vec == '0));

   p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend_vec) |=> irq_o);

   p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|pend_vec) |=> !irq_o);

   p_masked_edge_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise_vec & ~en_vec)) |=> ((edge_lat_vec & $past(rise_vec & ~en_vec & ~edge_lat_vec)) == '0));

   p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise_vec & en_vec)) |=> (($past(rise_vec & en_vec) & ~edge_lat_vec) == '0));

   generate
      for (genvar k = 0; k < N_BANKS; k++) begin : g_clr
         p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == 2'(k)) |=>
               ((edge_lat_vec[k*DATA_W +: DATA_W] &
                 ~$past(rise_vec[k*DATA_W +: DATA_W] & en_vec[k*DATA_W +: DATA_W])) == '0));
      end
   endgenerate
endmodule

bind irq_cascade_agg irq_agg_checker #(.N_BANKS(N_BANKS), .DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_en        (rd_en),
   .addr         (addr),
   .irq_o        (irq_o),
   .en_vec       (en_vec),
   .rise_vec     (rise_vec),
   .edge_lat_vec (edge_lat_vec),
   .pend_vec     (pend_vec)
);

// File: tb/irq_cascade_agg_tb.sv
`timescale 1ns/1ps
module irq_cascade_agg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] src_i = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        irq_o;

   int n_checks = 0;
   int n_errors = 0;

   typedef struct {
      logic [7:0] val;
      string      req;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   irq_cascade_agg dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_i),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq_o   (irq_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops an expected byte for every read cycle
   always @(negedge clk) begin
      exp_t e;
      #5;
      if (rd_en && sb_q.size() > 0) begin
         e = sb_q.pop_front();
         chk(e.req, rd_data, e.val);
      end
   end

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      sb_q.push_back('{exp, req});
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [23:0] m);
      @(negedge clk); src_i = src_i | m;
      @(negedge clk); src_i = src_i & ~m;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R4 reset state
      chk("R4 irq", {7'b0, irq_o}, 8'h00);
      rd(0, 8'h00, "R4 status0");
      rd(1, 8'h00, "R4 status1");
      rd(2, 8'h00, "R4 status2");
      rd(3, 8'h00, "R4 enable view");

      // R2 enable bytes and auxiliary view
      wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hFF);
      wr(3, 8'h00); rd(3, 8'hA5, "R2 view0");
      wr(3, 8'h01); rd(3, 8'h3C, "R2 view1");
      wr(3, 8'h02); rd(3, 8'hFF, "R2 view2");
      wr(3, 8'h07); rd(3, 8'h00, "R2 view out of range");

      // R9 latency, R1 bank mapping, R6 read clear, R7 deassert
      @(negedge clk); src_i[2] = 1'b1;
      @(negedge clk); src_i[2] = 1'b0;
      @(negedge clk);
      @(negedge clk); chk("R9 not yet", {7'b0, irq_o}, 8'h00);
      @(negedge clk); chk("R9 raised", {7'b0, irq_o}, 8'h01);
      rd(0, 8'h04, "R1 bank0 bit2");
      idle(1);
      chk("R7 falls after clear", {7'b0, irq_o}, 8'h00);
      rd(0, 8'h00, "R6 cleared");

      // R1 bank2 mapping and R6 per-bank clearing
      pulse(24'h20_0000);
      idle(6);
      rd(0, 8'h00, "R6 other bank read");
      rd(2, 8'h20, "R1 bank2 bit5");
      rd(2, 8'h00, "R6 bank2 cleared");

      // R7 with two banks pending
      pulse(24'h00_2004);
      idle(6);
      chk("R7 two pending", {7'b0, irq_o}, 8'h01);
      rd(0, 8'h04, "R7 bank0");
      idle(2);
      chk("R7 bank1 still pending", {7'b0, irq_o}, 8'h01);
      rd(1, 8'h20, "R7 bank1");
      idle(2);
      chk("R7 all clear", {7'b0, irq_o}, 8'h00);

      // R5 masked edge dropped; already-high input when unmasked is missed
      pulse(24'h00_0002);
      idle(6);
      chk("R5 masked edge irq", {7'b0, irq_o}, 8'h00);
      rd(0, 8'h00, "R5 masked edge status");
      wr(0, 8'hA4);
      @(negedge clk); src_i[0] = 1'b1;
      idle(6);
      wr(0, 8'hA5);
      idle(6);
      chk("R5 held input after unmask irq", {7'b0, irq_o}, 8'h00);
      rd(0, 8'h00, "R5 held input after unmask status");
      @(negedge clk); src_i[0] = 1'b0;
      idle(4);
      pulse(24'h00_0001);
      idle(6);
      rd(0, 8'h01, "R5 next edge captured");

      // R3 level source
      @(negedge clk); src_i[11] = 1'b1;
      idle(5);
      chk("R3 level irq", {7'b0, irq_o}, 8'h01);
      rd(1, 8'h08, "R3 level status");
      rd(1, 8'h08, "R3 level not cleared");
      @(negedge clk); src_i[11] = 1'b0;
      idle(5);
      chk("R3 level released irq", {7'b0, irq_o}, 8'h00);
      rd(1, 8'h00, "R3 level released status");
      wr(1, 8'h34);
      @(negedge clk); src_i[11] = 1'b1;
      idle(5);
      chk("R3 masked level irq", {7'b0, irq_o}, 8'h00);
      rd(1, 8'h08, "R3 masked level status live");
      @(negedge clk); src_i[11] = 1'b0;
      idle(4);
      wr(1, 8'h3C);

      // R8 edge in the same cycle as the clearing read
      @(negedge clk); src_i[2] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      rd(0, 8'h00, "R8 race read");
      src_i[2] = 1'b0;
      idle(1);
      chk("R8 irq after race", {7'b0, irq_o}, 8'h01);
      rd(0, 8'h04, "R8 bit kept");
      idle(3);
      finish_run();
   end
endmodule